// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the minimum-mode bus interface of a simple processor. It takes one memory or I/O transfer at a time from an internal request port and runs it on an external bus. On that bus the lower address lines and the data lines share the same wires, and the upper address lines also carry status bits. Each transfer runs through fixed clock phases T1, T2, T3 and T4. A slow device can stretch the transfer by holding READY low, which adds wait phases. An external bus master can take the bus with HOLD: the block finishes the transfer in progress, lets go of its drivers and answers with HLDA.

The requester places an address, write data, a direction bit and a memory/I/O bit on the request port and raises `req_valid`. `req_taken` pulses in the clock in which the request is latched. `rsp_done` pulses for one clock in the last phase, and for a read `rsp_rdata` holds the captured word at that time. The block shows its tristate drivers as output-enable ports (`ad_oe`, `ahi_oe`, `ctl_oe`) and does not contain the tristate buffers themselves.

Top module: `mux_bus_seq`

## Requirements
- R1: While reset is asserted and in the first idle clock after it: `ale`=0, `rd_n`=`wr_n`=`den_n`=1, `hlda`=0, `rsp_done`=0, `ad_oe`=0, `ahi_oe`=0, `ctl_oe`=1.
- R2: In T1, the first clock after a request is taken, `ale`=1 for exactly that clock. The multiplexed lines carry address bits [DW-1:0] with `ad_oe`=1, the upper lines carry address bits [AW-1:DW] with `ahi_oe`=1, and all strobes stay inactive.
- R3: From T2 through T4 the upper lines carry status. The top bit is 0, the bit below it equals the `int_en` input, and the remaining lower bits are 0.
- R4: In a read (`req_write`=0), `rd_n` and `den_n` are low from T2 through T3, including any wait phases. `ad_oe` is 0 from T2 onward and `dt_r`=0 from T1 to T4.
- R5: In a write (`req_write`=1), `wr_n` and `den_n` are low from T2 through T3. The write data is on `ad_out` with `ad_oe`=1 from T2 through T4, and `dt_r`=1 from T1 to T4.
- R6: READY is sampled at the clock edge that ends T2 and at the edge that ends every wait phase. Each low sample adds one wait phase with the strobes held, so a transfer with N low samples lasts 4+N clocks.
- R7: For a read, the value on `ad_in` at the edge that ends T3 appears on `rsp_rdata`. In T4 `rsp_done`=1 for that single clock, and `rd_n`, `wr_n` and `den_n` are all 1.
- R8: `m_io` is 1 for a memory transfer (`req_io`=0) and 0 for an I/O transfer (`req_io`=1) from T1 through T4.
- R9: A request is taken only in idle or in T4, and `req_taken` is 0 in every other phase. A request present in T4 starts T1 in the very next clock.
- R10: When `hold`=1, the transfer in progress finishes. From the next idle point, `hlda`=1 and `ad_oe`, `ahi_oe`, `ctl_oe` and `ale` are all 0, and no request is taken. Hold raised in idle is granted after one clock. After hold drops, the block is idle one clock later with `hlda`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| int_en | input | 1 | Interrupt-enable flag shown in status |
| req_taken | output | 1 | Request latched this clock |
| rsp_done | output | 1 | One-clock completion pulse in T4 |
| rsp_rdata | output | DW | Captured read data |
| ad_out | output | DW | Multiplexed address/data drive value |
| ad_oe | output | 1 | Drive enable for multiplexed lines |
| ad_in | input | DW | Multiplexed lines as seen from the bus |
| ahi_out | output | AW-DW | Upper address / status value |
| ahi_oe | output | 1 | Drive enable for upper lines |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data buffer enable, active low |
| dt_r | output | 1 | Buffer direction, 1 = transmit |
| m_io | output | 1 | 1 = memory, 0 = I/O |
| ctl_oe | output | 1 | Drive enable for rd_n, wr_n, den_n, dt_r, m_io |
| ready | input | 1 | Device ready; low adds wait phases |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus released |

## Verification
The bench changes `ad_in` so that it differs in T2, T3 and T4. A design that captures read data one phase early or late then returns a visibly wrong word. It runs transfers with zero, one and three wait phases and checks the strobes in every phase, so a design that samples READY only once, or that samples it in T3, ends the transfer too soon or too late. Hold is raised in the middle of a transfer and again in idle. A design that floats the bus before T4, grants hold late, or takes a request while released fails on the enables or on `req_taken`. A request held through a whole transfer checks that only T4 accepts it and that T1 follows T4 at once.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_write,
  input  logic          req_io,
  input  logic          int_en,
  output logic          req_taken,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic [AW-DW-1:0] ahi_out,
  output logic          ahi_oe,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          den_n,
  output logic          dt_r,
  output logic          m_io,
  output logic          ctl_oe,
  input  logic          ready,
  input  logic          hold,
  output logic          hlda
);
  localparam int HW = AW - DW;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_TW, S_T3, S_T4, S_HELD} st_t;
  st_t st, st_nx;

  logic [AW-1:0] a_q;
  logic [DW-1:0] wd_q;
  logic wr_q, io_q;
  logic strobe;
  logic [HW-1:0] status;

  assign req_taken = req_valid && !hold && (st == S_IDLE || st == S_T4);

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  st_nx = hold ? S_HELD : (req_valid ? S_T1 : S_IDLE);
      S_T1:    st_nx = S_T2;
      S_T2:    st_nx = ready ? S_T3 : S_TW;
      S_TW:    st_nx = ready ? S_T3 : S_TW;
      S_T3:    st_nx = S_T4;
      S_T4:    st_nx = hold ? S_HELD : (req_valid ? S_T1 : S_IDLE);
      S_HELD:  st_nx = hold ? S_HELD : S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      a_q       <= '0;
      wd_q      <= '0;
      wr_q      <= 1'b0;
      io_q      <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st <= st_nx;
      if (req_taken) begin
        a_q  <= req_addr;
        wd_q <= req_wdata;
        wr_q <= req_write;
        io_q <= req_io;
      end
      if (st == S_T3 && !wr_q) rsp_rdata <= ad_in;
    end
  end

  always_comb begin
    status = '0;
    status[HW-2] = int_en;
  end

  assign strobe   = (st == S_T2) || (st == S_TW) || (st == S_T3);
  assign ale      = (st == S_T1);
  assign ad_oe    = (st == S_T1) || (wr_q && (strobe || st == S_T4));
  assign ad_out   = (st == S_T1) ? a_q[DW-1:0] : wd_q;
  assign ahi_oe   = (st == S_T1) || strobe || (st == S_T4);
  assign ahi_out  = (st == S_T1) ? a_q[AW-1:DW] : status;
  assign rd_n     = !(strobe && !wr_q);
  assign wr_n     = !(strobe && wr_q);
  assign den_n    = !strobe;
  assign dt_r     = wr_q;
  assign m_io     = !io_q;
  assign ctl_oe   = (st != S_HELD);
  assign hlda     = (st == S_HELD);
  assign rsp_done = (st == S_T4);

  // R4 R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R2
  ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!ad_oe && !ahi_oe && !ctl_oe && !ale && !req_taken));

  // R6
  wait_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_T2 || st == S_TW) && !ready) |=> (st == S_TW && !den_n));

  // R4 R5
  dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T2 || st == S_TW || st == S_T3 || st == S_T4) |-> $stable(dt_r));

  // R10
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && st == S_IDLE) |=> hlda);
endmodule

// File: tb/mux_bus_seq_bench.sv
module mux_bus_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, int_en = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0, ad_in = '0;
  logic ready = 1'b1, hold = 1'b0;
  logic req_taken, rsp_done, ad_oe, ahi_oe, ale, rd_n, wr_n, den_n, dt_r, m_io, ctl_oe, hlda;
  logic [15:0] rsp_rdata, ad_out;
  logic [3:0] ahi_out;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  mux_bus_seq #(.AW(20), .DW(16)) u_mux_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io), .int_en(int_en),
    .req_taken(req_taken), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ahi_out(ahi_out), .ahi_oe(ahi_oe),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r), .m_io(m_io),
    .ctl_oe(ctl_oe), .ready(ready), .hold(hold), .hlda(hlda));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic strobes(input string r, input bit w);
    chk({r, " rd_n"}, rd_n, w);
    chk({r, " wr_n"}, wr_n, !w);
    chk({r, " den_n"}, den_n, 0);
  endtask

  task automatic bus_xfer(input bit w, input bit io, input logic [19:0] a,
                          input logic [15:0] d, input int nw, input bit ie,
                          input bit now, input bit keep);
    if (!now) @(negedge clk);
    req_valid = 1; req_write = w; req_io = io; req_addr = a; req_wdata = d;
    int_en = ie; ready = 1;
    #1 chk("R9 taken in idle/T4", req_taken, 1);
    @(negedge clk);
    chk("R2 ale", ale, 1);
    chk("R2 addr low", {ad_oe, ad_out}, {1'b1, a[15:0]});
    chk("R2 addr high", {ahi_oe, ahi_out}, {1'b1, a[19:16]});
    chk("R2 strobes idle", {rd_n, wr_n, den_n}, 3'b111);
    chk("R4 R5 dt_r T1", dt_r, w);
    chk("R8 m_io T1", m_io, !io);
    if (!keep) req_valid = 0;
    ready = (nw == 0);
    ad_in = 16'hDEAD;
    @(negedge clk);
    chk("R2 ale low T2", ale, 0);
    strobes(w ? "R5 T2" : "R4 T2", w);
    chk("R3 status", {ahi_oe, ahi_out}, {1'b1, 1'b0, ie, 2'b00});
    chk(w ? "R5 data oe" : "R4 no drive", ad_oe, w);
    if (w) chk("R5 wdata", ad_out, d);
    if (keep) chk("R9 not taken T2", req_taken, 0);
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);
      strobes("R6 wait", w);
      chk("R6 no done in wait", rsp_done, 0);
      chk("R3 status wait", ahi_out, {1'b0, ie, 2'b00});
      ready = (i == nw - 1);
    end
    @(negedge clk);
    strobes(w ? "R5 T3" : "R4 T3", w);
    chk("R7 no done T3", rsp_done, 0);
    if (keep) chk("R9 not taken T3", req_taken, 0);
    ad_in = d;
    @(negedge clk);
    chk("R7 strobes off T4", {rd_n, wr_n, den_n}, 3'b111);
    chk("R7 done", rsp_done, 1);
    if (!w) chk("R7 rdata", rsp_rdata, d);
    chk("R4 R5 dt_r T4", dt_r, w);
    chk("R8 m_io T4", m_io, !io);
    chk("R3 status T4", ahi_out, {1'b0, ie, 2'b00});
    if (w) chk("R5 data held T4", {ad_oe, ad_out}, {1'b1, d});
    ad_in = ~d;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 reset strobes", {ale, rd_n, wr_n, den_n}, 4'b0111);
    chk("R1 reset hlda/done", {hlda, rsp_done}, 2'b00);
    chk("R1 reset oe", {ad_oe, ahi_oe, ctl_oe}, 3'b001);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {ale, rd_n, wr_n, den_n, hlda, rsp_done, ad_oe, ahi_oe}, 8'b01110000);
  endtask

  task automatic t_idle_after;
    @(negedge clk);
    chk("R7 done one clock", rsp_done, 0);
    chk("R9 idle no ale", ale, 0);
  endtask

  task automatic t_b2b;
    bus_xfer(1, 0, 20'hA1234, 16'h5A5A, 0, 0, 0, 1);
    bus_xfer(0, 1, 20'h00F0F, 16'h1357, 1, 1, 1, 0);
  endtask

  task automatic t_hold_mid;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_io = 0; req_addr = 20'h3C001; ready = 1;
    @(negedge clk);
    req_valid = 0; hold = 1; ad_in = 16'hDEAD;
    @(negedge clk);
    chk("R10 cycle continues T2", {rd_n, hlda}, 2'b00);
    @(negedge clk);
    chk("R10 cycle continues T3", {rd_n, hlda, ctl_oe}, 3'b001);
    ad_in = 16'hBEEF;
    @(negedge clk);
    chk("R10 finish T4", {rsp_done, hlda}, 2'b10);
    chk("R10 rdata", rsp_rdata, 16'hBEEF);
    req_valid = 1;
    #1 chk("R10 no take under hold", req_taken, 0);
    @(negedge clk);
    chk("R10 released", {hlda, ad_oe, ahi_oe, ctl_oe, ale}, 5'b10000);
    chk("R10 no take held", req_taken, 0);
    req_valid = 0;
    @(negedge clk);
    chk("R10 still held", hlda, 1);
    hold = 0;
    @(negedge clk);
    chk("R10 back idle", {hlda, ctl_oe, ale}, 3'b010);
  endtask

  task automatic t_hold_idle;
    @(negedge clk);
    hold = 1;
    @(negedge clk);
    chk("R10 grant from idle", {hlda, ctl_oe}, 2'b10);
    hold = 0;
    @(negedge clk);
    chk("R10 release from idle", hlda, 0);
  endtask

  initial begin
    t_reset();
    bus_xfer(0, 0, 20'h12345, 16'hC0DE, 0, 1, 0, 0);
    t_idle_after();
    bus_xfer(1, 1, 20'hFEDCB, 16'h8001, 0, 0, 0, 0);
    t_idle_after();
    bus_xfer(0, 1, 20'h0AAAA, 16'h7E7E, 3, 1, 0, 0);
    bus_xfer(1, 0, 20'h55555, 16'hFFFF, 1, 1, 0, 0);
    t_b2b();
    t_idle_after();
    t_hold_mid();
    t_hold_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule